// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This unit sits beside an Ethernet port and looks at the start-of-packet event of each PTP event message, in both the transmit and the receive direction. For each event it is given the message type, the sequence ID and the direction. It also receives the present seconds and nanoseconds from an external time-of-day counter. A 16-bit action word per direction holds a 2-bit action code for each event message type. The byte that applies depends on whether the frame belongs to the line side or the CPU side. The unit decodes that code and reports the chosen action one cycle later.

When a transmit event is enabled, the unit stores the time of its start of packet in a small queue. Each entry is tagged with the sequence ID, the message type and the direction. A host drains the queue with a start / read words / end / clear handshake, and a status word shows when entries are waiting or when a capture was lost.

For an enabled receive event, the unit presents the eight (or six) bytes that a downstream inserter writes after the PTP header. Frame parsing, the insertion datapath, the management bus and the time counter are outside this block.

Top module: `ptp_tsu`

## Requirements
- R1: A transmit event is queued only when the transmit slice enable (`slice_cfg` bit 0) is set, the global capture enable is high and its action code is nonzero. With `glb_cap_en` low and the slice enabled, `tx_op_valid` still fires but nothing is queued.
- R2: A receive event gives `rx_op_valid` only when the receive slice enable (`slice_cfg` bit 8) is set. A receive event never enters the capture queue.
- R3: The action code for message type t (0 Sync, 1 Delay_Req, 2 Pdelay_Req, 3 Pdelay_Resp) is bits [2t+1:2t] of the mode word for line-side frames, and bits [2t+9:2t+8] for CPU-side frames.
- R4: One cycle after an enabled event with a nonzero code, `tx_op_valid`/`rx_op_valid` is high and `tx_op`/`rx_op` carries the code. On transmit, bit 0 means correction update and 2'b11 means timestamp and correction replace. On receive, bit 0 means correction update, 2'b10 means 48-bit insert and 2'b11 means 64-bit insert.
- R5: For receive code 2'b11, `rx_ts_bytes` is {seconds[31:0], nanoseconds[31:0]}, with the first transmitted byte in bits 63:56.
- R6: For receive code 2'b10, `rx_ts_bytes` is {seconds[15:0], nanoseconds[31:0], 16'h0000}.
- R7: During a read, `hrd_sel` picks the entry word as follows: 0 ns[15:0], 1 ns[31:16], 2 s[15:0], 3 s[31:16], 4 sequence ID, 5 info. The info word is {message type in 15:12, transmit flag in 11, zeros}.
- R8: `irq_status` bit 1 is high exactly while at least one entry is queued. All status bits are zero after reset.
- R9: Writing `hctl_wdata` bit 0 from the idle state latches the oldest entry. Writing bit 1 after that removes it. Writing zero returns to idle. An end write without a preceding start removes nothing.
- R10: The queue holds QDEPTH (4) entries. A capture that arrives while the queue is full is dropped and sets the sticky `irq_status` bit 2.
- R11: Message types above 3 never produce an action, a capture or an insert.
- R12: Entries are read out in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_cfg | input | 16 | Bit 0 enables transmit, bit 8 enables receive |
| glb_cap_en | input | 1 | Global transmit capture enable |
| tx_mode | input | 16 | Transmit action codes, line byte low, CPU byte high |
| rx_mode | input | 16 | Receive action codes, same layout |
| ev_valid | input | 1 | Start-of-packet event strobe |
| ev_is_tx | input | 1 | Event direction, 1 = transmit |
| ev_cpu_side | input | 1 | Selects the CPU-side action byte |
| ev_msgtype | input | 4 | PTP message type |
| ev_seqid | input | 16 | PTP sequence ID |
| tod_sec | input | 32 | Current seconds |
| tod_nsec | input | 32 | Current nanoseconds |
| tx_op_valid | output | 1 | Transmit action strobe |
| tx_op | output | 2 | Transmit action code |
| rx_op_valid | output | 1 | Receive action strobe |
| rx_op | output | 2 | Receive action code |
| rx_ts_bytes | output | 64 | Bytes to insert, first byte in 63:56 |
| hctl_we | input | 1 | Host write strobe for the read-control word |
| hctl_wdata | input | 16 | Read-control word, bit 0 start, bit 1 end |
| hrd_sel | input | 3 | Word select for the latched entry |
| hrd_data | output | 16 | Selected word of the latched entry |
| irq_status | output | 16 | Bit 1 entries pending, bit 2 overflow |

## Verification
On every cycle, the assertions check that gating works: a disabled transmit slice, a low global enable or a non-event type never leads to a queue push, and a receive strobe only follows an enabled receive slice. They also check that the occupancy stays within QDEPTH, that a full queue stays full when a capture is dropped, that the overflow flag stays set once set, and that pending goes high after a push. Only the bench scenarios can show other properties. These are the field selection for each message type and side, the bit layout of the words that are read back and of the inserted bytes, the timestamp values, the first-in order, and the rule that an end write without a start removes nothing.

// File: rtl/ptp_tsu_pkg.sv
package ptp_tsu_pkg;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 32;
    localparam int SEQ_W  = 16;
    localparam int MT_W   = 4;
    localparam int WORD_W = 16;
    localparam int NUM_EVT_TYPES = 4;

    localparam int TX_SLICE_BIT   = 0;
    localparam int RX_SLICE_BIT   = 8;
    localparam int CPU_BYTE_SHIFT = 8;
    localparam int HS_START_BIT   = 0;
    localparam int HS_END_BIT     = 1;
    localparam int ST_PEND_BIT    = 1;
    localparam int ST_OVF_BIT     = 2;

    localparam logic [1:0] ACT_NONE = 2'b00;
    localparam logic [1:0] ACT_TS48 = 2'b10;
    localparam logic [1:0] ACT_TS64 = 2'b11;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  nsec;
        logic [SEQ_W-1:0] seqid;
        logic [MT_W-1:0]  mtype;
        logic             is_tx;
    } cap_entry_t;

    typedef enum logic [1:0] {RD_IDLE, RD_OPEN, RD_DONE} rd_state_t;

    function automatic logic is_event(input logic [MT_W-1:0] mt);
        return mt < MT_W'(NUM_EVT_TYPES);
    endfunction

    function automatic logic [1:0] pick_action(input logic [15:0] mode,
                                               input logic cpu,
                                               input logic [MT_W-1:0] mt);
        logic [3:0] base;
        base = (cpu ? 4'(CPU_BYTE_SHIFT) : 4'd0) + {1'b0, mt[1:0], 1'b0};
        return is_event(mt) ? mode[base +: 2] : ACT_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input cap_entry_t e,
                                                  input logic [2:0] sel);
        case (sel)
            3'd0:    return e.nsec[15:0];
            3'd1:    return e.nsec[31:16];
            3'd2:    return e.sec[15:0];
            3'd3:    return e.sec[31:16];
            3'd4:    return e.seqid;
            3'd5:    return {e.mtype, e.is_tx, 11'b0};
            default: return '0;
        endcase
    endfunction

    function automatic logic [63:0] insert_bytes(input logic [SEC_W-1:0] s,
                                                 input logic [NS_W-1:0] ns,
                                                 input logic [1:0] code);
        case (code)
            ACT_TS64: return {s, ns};
            ACT_TS48: return {s[15:0], ns, 16'h0000};
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/ptp_evt_decode.sv
module ptp_evt_decode
    import ptp_tsu_pkg::*;
(
    input  logic            en,
    input  logic            ev_valid,
    input  logic            dir_ok,
    input  logic            cpu_side,
    input  logic [MT_W-1:0] msgtype,
    input  logic [15:0]     mode,
    output logic            hit,
    output logic [1:0]      code
);
    always_comb begin
        code = pick_action(mode, cpu_side, msgtype);
        hit  = en && ev_valid && dir_ok && (code != ACT_NONE);
    end
endmodule

// File: rtl/ptp_cap_queue.sv
module ptp_cap_queue
    import ptp_tsu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  cap_entry_t                   din,
    input  logic                         pop,
    output cap_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    cap_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/ptp_host_reader.sv
module ptp_host_reader
    import ptp_tsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [15:0]       wdata,
    input  cap_entry_t        q_head,
    input  logic              q_empty,
    output logic              pop,
    input  logic [2:0]        sel,
    output logic [WORD_W-1:0] rdata
);
    rd_state_t  state;
    cap_entry_t snap;
    logic       snap_ok;

    assign rdata = word_of(snap, sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RD_IDLE;
            snap    <= '0;
            snap_ok <= 1'b0;
            pop     <= 1'b0;
        end else begin
            pop <= 1'b0;
            if (we) begin
                if (wdata == '0) begin
                    state <= RD_IDLE;
                end else if (wdata[HS_START_BIT] && state == RD_IDLE) begin
                    snap    <= q_head;
                    snap_ok <= !q_empty;
                    state   <= RD_OPEN;
                end else if (wdata[HS_END_BIT] && state == RD_OPEN) begin
                    pop     <= snap_ok;
                    snap_ok <= 1'b0;
                    state   <= RD_DONE;
                end
            end
        end
    end
endmodule

// File: rtl/ptp_tsu.sv
module ptp_tsu
    import ptp_tsu_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] slice_cfg,
    input  logic        glb_cap_en,
    input  logic [15:0] tx_mode,
    input  logic [15:0] rx_mode,
    input  logic        ev_valid,
    input  logic        ev_is_tx,
    input  logic        ev_cpu_side,
    input  logic [3:0]  ev_msgtype,
    input  logic [15:0] ev_seqid,
    input  logic [31:0] tod_sec,
    input  logic [31:0] tod_nsec,
    output logic        tx_op_valid,
    output logic [1:0]  tx_op,
    output logic        rx_op_valid,
    output logic [1:0]  rx_op,
    output logic [63:0] rx_ts_bytes,
    input  logic        hctl_we,
    input  logic [15:0] hctl_wdata,
    input  logic [2:0]  hrd_sel,
    output logic [15:0] hrd_data,
    output logic [15:0] irq_status
);
    localparam int CNT_W = $clog2(QDEPTH+1);

    logic [1:0]  dir_en, dir_ok, dir_hit;
    logic [1:0]  dir_code [2];
    logic [15:0] dir_mode [2];

    assign dir_en      = {slice_cfg[RX_SLICE_BIT], slice_cfg[TX_SLICE_BIT]};
    assign dir_ok      = {!ev_is_tx, ev_is_tx};
    assign dir_mode[0] = tx_mode;
    assign dir_mode[1] = rx_mode;

    for (genvar d = 0; d < 2; d++) begin : g_dir
        ptp_evt_decode u_dec (
            .en       (dir_en[d]),
            .ev_valid (ev_valid),
            .dir_ok   (dir_ok[d]),
            .cpu_side (ev_cpu_side),
            .msgtype  (ev_msgtype),
            .mode     (dir_mode[d]),
            .hit      (dir_hit[d]),
            .code     (dir_code[d])
        );
    end

    logic             cap_push, q_pop, q_ovf;
    logic [CNT_W-1:0] q_count;
    cap_entry_t       new_entry, q_head;

    assign cap_push  = dir_hit[0] && glb_cap_en;
    assign new_entry = '{sec: tod_sec, nsec: tod_nsec, seqid: ev_seqid,
                         mtype: ev_msgtype, is_tx: ev_is_tx};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_op_valid <= 1'b0;
            tx_op       <= ACT_NONE;
            rx_op_valid <= 1'b0;
            rx_op       <= ACT_NONE;
            rx_ts_bytes <= '0;
        end else begin
            tx_op_valid <= dir_hit[0];
            tx_op       <= dir_hit[0] ? dir_code[0] : ACT_NONE;
            rx_op_valid <= dir_hit[1];
            rx_op       <= dir_hit[1] ? dir_code[1] : ACT_NONE;
            rx_ts_bytes <= dir_hit[1] ? insert_bytes(tod_sec, tod_nsec, dir_code[1]) : '0;
        end
    end

    ptp_cap_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (cap_push),
        .din      (new_entry),
        .pop      (q_pop),
        .head     (q_head),
        .count    (q_count),
        .overflow (q_ovf)
    );

    ptp_host_reader u_reader (
        .clk     (clk),
        .rst     (rst),
        .we      (hctl_we),
        .wdata   (hctl_wdata),
        .q_head  (q_head),
        .q_empty (q_count == '0),
        .pop     (q_pop),
        .sel     (hrd_sel),
        .rdata   (hrd_data)
    );

    always_comb begin
        irq_status              = '0;
        irq_status[ST_PEND_BIT] = (q_count != '0);
        irq_status[ST_OVF_BIT]  = q_ovf;
    end
endmodule

// File: rtl/ptp_tsu_checks.sv
module ptp_tsu_checks #(
    parameter int QDEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [15:0]                slice_cfg,
    input logic                       glb_cap_en,
    input logic                       ev_valid,
    input logic                       ev_is_tx,
    input logic [3:0]                 ev_msgtype,
    input logic                       cap_push,
    input logic                       q_pop,
    input logic [$clog2(QDEPTH+1)-1:0] q_count,
    input logic                       rx_op_valid,
    input logic [15:0]                irq_status
);
    assert_tx_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_is_tx && !(slice_cfg[0] && glb_cap_en)) |-> !cap_push);

    assert_rx_gate_R2: assert property (@(posedge clk) disable iff (rst)
        rx_op_valid |-> $past(slice_cfg[8] && ev_valid && !ev_is_tx));

    assert_non_event_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_msgtype > 4'd3) |-> !cap_push);

    assert_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_push && !q_pop) |=> irq_status[1]);

    assert_bound_R10: assert property (@(posedge clk) disable iff (rst)
        q_count <= ($clog2(QDEPTH+1))'(QDEPTH));

    assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (cap_push && !q_pop && q_count == ($clog2(QDEPTH+1))'(QDEPTH))
        |=> (q_count == ($clog2(QDEPTH+1))'(QDEPTH)) && irq_status[2]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        irq_status[2] |=> irq_status[2]);
endmodule

bind ptp_tsu ptp_tsu_checks #(.QDEPTH(QDEPTH)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .slice_cfg   (slice_cfg),
    .glb_cap_en  (glb_cap_en),
    .ev_valid    (ev_valid),
    .ev_is_tx    (ev_is_tx),
    .ev_msgtype  (ev_msgtype),
    .cap_push    (cap_push),
    .q_pop       (q_pop),
    .q_count     (q_count),
    .rx_op_valid (rx_op_valid),
    .irq_status  (irq_status)
);

// File: tb/ptp_tsu_test.sv
`timescale 1ns/1ps
module ptp_tsu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] slice_cfg = '0;
    logic        glb_cap_en = 1'b0;
    logic [15:0] tx_mode = '0, rx_mode = '0;
    logic        ev_valid = 1'b0, ev_is_tx = 1'b0, ev_cpu_side = 1'b0;
    logic [3:0]  ev_msgtype = '0;
    logic [15:0] ev_seqid = '0;
    logic [31:0] tod_sec = '0, tod_nsec = '0;
    logic        tx_op_valid, rx_op_valid;
    logic [1:0]  tx_op, rx_op;
    logic [63:0] rx_ts_bytes;
    logic        hctl_we = 1'b0;
    logic [15:0] hctl_wdata = '0;
    logic [2:0]  hrd_sel = '0;
    logic [15:0] hrd_data, irq_status;

    int n_cmp = 0, n_bad = 0;
    logic finished = 1'b0;

    ptp_tsu uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] sec_of(input logic [15:0] s);
        return 32'h4000_0000 + 32'(s) * 32'd7;
    endfunction
    function automatic logic [31:0] ns_of(input logic [15:0] s);
        return {s ^ 16'h3C5A, ~s};
    endfunction

    logic       got_txv, got_rxv;
    logic [1:0] got_tx, got_rx;
    logic [63:0] got_bytes;

    task automatic send(input logic tx, input logic cpu, input logic [3:0] mt, input logic [15:0] seq);
        @(negedge clk);
        ev_valid = 1'b1; ev_is_tx = tx; ev_cpu_side = cpu; ev_msgtype = mt; ev_seqid = seq;
        tod_sec = sec_of(seq); tod_nsec = ns_of(seq);
        @(negedge clk);
        ev_valid = 1'b0;
        got_txv = tx_op_valid; got_tx = tx_op;
        got_rxv = rx_op_valid; got_rx = rx_op; got_bytes = rx_ts_bytes;
    endtask

    task automatic hwrite(input logic [15:0] d);
        @(negedge clk);
        hctl_we = 1'b1; hctl_wdata = d;
        @(negedge clk);
        hctl_we = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] seq, input logic [3:0] mt);
        logic [15:0] exp [6];
        exp[0] = ns_of(seq)[15:0];  exp[1] = ns_of(seq)[31:16];
        exp[2] = sec_of(seq)[15:0]; exp[3] = sec_of(seq)[31:16];
        exp[4] = seq;               exp[5] = {mt, 1'b1, 11'b0};
        hwrite(16'h0001);
        for (int w = 0; w < 6; w++) begin
            hrd_sel = 3'(w);
            #0.5;
            chk(req, 64'(hrd_data), 64'(exp[w]));
        end
        hwrite(16'h0002);
        hwrite(16'h0000);
    endtask

    function automatic logic [15:0] make_mode(input int tgt, input logic [1:0] code);
        logic [15:0] m;
        for (int f = 0; f < 8; f++) m[2*f +: 2] = (f == tgt) ? code : (code ^ 2'b01);
        return m;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] seq;
        logic [1:0]  ec;
        logic        ev;
        logic [63:0] eb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset status", 64'(irq_status), 64'h0);
        chk("R4 reset tx", 64'(tx_op_valid), 64'h0);
        chk("R2 reset rx", 64'(rx_op_valid), 64'h0);

        // R3 R4 R7 R8 R9 R11: transmit sweep over type, side and code
        slice_cfg = 16'h0101; glb_cap_en = 1'b1; seq = 16'h0010;
        for (int mt = 0; mt < 6; mt++)
            for (int cpu = 0; cpu < 2; cpu++)
                for (int code = 0; code < 4; code++) begin
                    tx_mode = make_mode(cpu*4 + mt, 2'(code));
                    ev = (mt < 4);
                    ec = ev ? 2'(code) : 2'b00;
                    send(1'b1, 1'(cpu), 4'(mt), seq);
                    chk("R3 tx valid", 64'(got_txv), 64'(ec != 0));
                    if (ec != 0) chk("R4 tx code", 64'(got_tx), 64'(ec));
                    if (mt >= 4) chk("R11 no tx op", 64'(got_txv), 64'h0);
                    chk("R8 pending", 64'(irq_status[1]), 64'(ec != 0));
                    if (ec != 0) begin
                        read_check("R7 entry", seq, 4'(mt));
                        chk("R9 popped", 64'(irq_status[1]), 64'h0);
                    end
                    seq++;
                end

        // R2 R5 R6 R11: receive sweep
        for (int mt = 0; mt < 6; mt++)
            for (int cpu = 0; cpu < 2; cpu++)
                for (int code = 0; code < 4; code++) begin
                    rx_mode = make_mode(cpu*4 + mt, 2'(code));
                    ec = (mt < 4) ? 2'(code) : 2'b00;
                    send(1'b0, 1'(cpu), 4'(mt), seq);
                    chk("R3 rx valid", 64'(got_rxv), 64'(ec != 0));
                    if (ec != 0) chk("R4 rx code", 64'(got_rx), 64'(ec));
                    eb = 64'h0;
                    if (ec == 2'b11) eb = {sec_of(seq), ns_of(seq)};
                    if (ec == 2'b10) eb = {sec_of(seq)[15:0], ns_of(seq), 16'h0};
                    if (ec[1]) chk(ec[0] ? "R5 bytes64" : "R6 bytes48", got_bytes, eb);
                    chk("R2 rx not queued", 64'(irq_status[1]), 64'h0);
                    seq++;
                end

        // R1 gating
        tx_mode = 16'hFFFF; rx_mode = 16'hFFFF;
        slice_cfg = 16'h0100;
        send(1'b1, 1'b0, 4'd0, 16'h0A00);
        chk("R1 slice off op", 64'(got_txv), 64'h0);
        chk("R1 slice off queue", 64'(irq_status[1]), 64'h0);
        slice_cfg = 16'h0101; glb_cap_en = 1'b0;
        send(1'b1, 1'b0, 4'd1, 16'h0A01);
        chk("R1 glb off op", 64'(got_txv), 64'h1);
        chk("R1 glb off queue", 64'(irq_status[1]), 64'h0);
        // R2 receive slice off
        slice_cfg = 16'h0001;
        send(1'b0, 1'b0, 4'd0, 16'h0A02);
        chk("R2 slice off", 64'(got_rxv), 64'h0);

        // R9 end without start removes nothing
        glb_cap_en = 1'b1;
        send(1'b1, 1'b0, 4'd2, 16'h0B00);
        hwrite(16'h0002);
        hwrite(16'h0000);
        chk("R9 stray end", 64'(irq_status[1]), 64'h1);
        read_check("R9 entry", 16'h0B00, 4'd2);
        chk("R9 empty", 64'(irq_status[1]), 64'h0);
        chk("R10 no overflow yet", 64'(irq_status[2]), 64'h0);

        // R10 R12 overflow and ordering
        for (int i = 0; i < 5; i++) send(1'b1, 1'b0, 4'd3, 16'h0C00 + 16'(i));
        chk("R10 overflow", 64'(irq_status[2]), 64'h1);
        for (int i = 0; i < 4; i++) read_check("R12 order", 16'h0C00 + 16'(i), 4'd3);
        chk("R10 fifth dropped", 64'(irq_status[1]), 64'h0);
        chk("R10 sticky", 64'(irq_status[2]), 64'h1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule